// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The local component holds one short outcome history per branch slot, and uses that history to pick a 2-bit counter. The global component uses one shared register of recent outcomes, from any branch, to pick its counter. A third table of 2-bit chooser counters, addressed by the branch address, decides which of the two answers becomes the final guess.

The fetch side presents an address on the lookup port. The final guess and both component guesses come back in the same cycle, with no register in the path. When the branch later resolves, the pipeline returns the address, the real outcome and the two component guesses it saw at lookup. On the next clock edge the block shifts the outcome into both histories and trains the counters. The chooser for that address moves only when the two components disagreed, and then toward the component that was right.

Top module: `tourn_pred`

## Requirements
- R1: Every counter is 2 bits wide and saturates at 0 and 3. Values 2 and 3 mean taken, 0 and 1 mean not taken. A counter at 3 still predicts taken after one not-taken outcome.
- R2: The local component selects a history entry with the low `LHT_IDX_W` address bits. That entry's `LHIST_W`-bit history indexes the local counter table, and the counter's direction is output on `pred_local`.
- R3: The global history register is `GHIST_W` bits wide. On every valid resolve, whatever the address, the outcome enters at bit 0 and the older bits move up one place. The register's value indexes the global counter table, whose direction is output on `pred_global`.
- R4: The chooser table is indexed by the low `META_IDX_W` address bits. A chooser value of 2 or 3 makes `pred_taken` equal `pred_global`. A value of 0 or 1 makes it equal `pred_local`.
- R5: A chooser counter changes only on a resolve where `rs_local_pred` and `rs_global_pred` differ. It is incremented when the global guess matched the outcome and decremented when the local guess did.
- R6: On a valid resolve, the addressed local history entry takes the outcome in at bit 0. The local counter it indexed and the global counter indexed by the global history are incremented on taken and decremented on not taken. All of this takes effect at the next rising clock edge.
- R7: While `rs_valid` is low, no table entry and no history changes, whatever the other resolve inputs hold.
- R8: The synchronous active-high reset sets every prediction counter to 1, every chooser counter to 2 and every history to 0. Straight after reset, every lookup returns not taken on all three outputs.
- R9: The lookup outputs are combinational from `lk_pc` and the present state. Address bits above the index widths are ignored, so two addresses with equal low bits get identical guesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final direction guess |
| pred_local | output | 1 | Local component guess |
| pred_global | output | 1 | Global component guess |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Actual outcome of the resolving branch |
| rs_local_pred | input | 1 | Local guess given at its lookup |
| rs_global_pred | input | 1 | Global guess given at its lookup |

## Verification
A corrupted counter, history bit or chooser state never shows up as a flag. It shows up only as a wrong guess, on the first lookup that lands on the damaged entry. So the stimulus is a resolve sequence worked out by hand, and all three outputs are checked before every update. A bad history shift then shows within one or two branches, because the next lookup reads a different counter. A wrong chooser step shows on the next disagreement at that address, where the final guess follows the wrong component.

// File: rtl/tpred_pkg.sv
package tpred_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT     = 2'b01;
    localparam ctr2_t SEL_WEAK_GLOBAL = 2'b10;

    typedef enum logic {
        PICK_LOCAL  = 1'b0,
        PICK_GLOBAL = 1'b1
    } pick_e;

    typedef struct packed {
        logic valid;
        logic taken;
        logic local_pred;
        logic global_pred;
    } outcome_t;

    function automatic logic ctr_says_taken(ctr2_t c);
        return c[1];
    endfunction

    function automatic ctr2_t ctr_step(ctr2_t c, logic up);
        if (up) begin
            return (c == 2'b11) ? c : c + 2'b01;
        end
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    function automatic pick_e pick_from(ctr2_t c);
        return c[1] ? PICK_GLOBAL : PICK_LOCAL;
    endfunction

endpackage

// File: rtl/tpred_ctr_table.sv
module tpred_ctr_table
    import tpred_pkg::*;
#(
    parameter int    IDX_W = 4,
    parameter ctr2_t INIT  = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic [IDX_W-1:0] rs_idx,
    output ctr2_t            rs_ctr,
    input  logic             wr_en,
    input  ctr2_t            wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= INIT;
            end
        end else if (wr_en) begin
            mem[rs_idx] <= wr_ctr;
        end
    end

    assign rd_ctr = mem[rd_idx];
    assign rs_ctr = mem[rs_idx];
endmodule

// File: rtl/tpred_local.sv
module tpred_local
    import tpred_pkg::*;
#(
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LHT_IDX_W-1:0] lk_idx,
    output logic                 lk_taken,
    input  logic [LHT_IDX_W-1:0] rs_idx,
    input  logic                 rs_en,
    input  logic                 rs_taken
);
    localparam int ENTRIES = 1 << LHT_IDX_W;

    logic [LHIST_W-1:0] hist_tab [ENTRIES];
    logic [LHIST_W-1:0] lk_hist;
    logic [LHIST_W-1:0] rs_hist;
    logic [LHIST_W-1:0] rs_hist_next;
    ctr2_t              lk_ctr;
    ctr2_t              rs_ctr;

    assign lk_hist = hist_tab[lk_idx];
    assign rs_hist = hist_tab[rs_idx];

    generate
        if (LHIST_W == 1) begin : g_hist1
            assign rs_hist_next = rs_taken;
        end else begin : g_histn
            assign rs_hist_next = {rs_hist[LHIST_W-2:0], rs_taken};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                hist_tab[i] <= '0;
            end
        end else if (rs_en) begin
            hist_tab[rs_idx] <= rs_hist_next;
        end
    end

    tpred_ctr_table #(
        .IDX_W (LHIST_W),
        .INIT  (CTR_WEAK_NT)
    ) u_pht (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (lk_hist),
        .rd_ctr (lk_ctr),
        .rs_idx (rs_hist),
        .rs_ctr (rs_ctr),
        .wr_en  (rs_en),
        .wr_ctr (ctr_step(rs_ctr, rs_taken))
    );

    assign lk_taken = ctr_says_taken(lk_ctr);
endmodule

// File: rtl/tpred_global.sv
module tpred_global
    import tpred_pkg::*;
#(
    parameter int GHIST_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    output logic               lk_taken,
    input  logic               rs_en,
    input  logic               rs_taken,
    output logic [GHIST_W-1:0] ghr
);
    logic [GHIST_W-1:0] ghr_next;
    ctr2_t              lk_ctr;
    ctr2_t              rs_ctr;

    generate
        if (GHIST_W == 1) begin : g_ghr1
            assign ghr_next = rs_taken;
        end else begin : g_ghrn
            assign ghr_next = {ghr[GHIST_W-2:0], rs_taken};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ghr <= '0;
        end else if (rs_en) begin
            ghr <= ghr_next;
        end
    end

    tpred_ctr_table #(
        .IDX_W (GHIST_W),
        .INIT  (CTR_WEAK_NT)
    ) u_pht (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (ghr),
        .rd_ctr (lk_ctr),
        .rs_idx (ghr),
        .rs_ctr (rs_ctr),
        .wr_en  (rs_en),
        .wr_ctr (ctr_step(rs_ctr, rs_taken))
    );

    assign lk_taken = ctr_says_taken(lk_ctr);
endmodule

// File: rtl/tpred_chooser.sv
module tpred_chooser
    import tpred_pkg::*;
#(
    parameter int META_IDX_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [META_IDX_W-1:0] lk_idx,
    output pick_e                 lk_pick,
    input  logic [META_IDX_W-1:0] rs_idx,
    input  outcome_t              rs
);
    ctr2_t lk_ctr;
    ctr2_t rs_ctr;
    logic  disagree;
    logic  global_right;

    assign disagree     = rs.local_pred ^ rs.global_pred;
    assign global_right = (rs.global_pred == rs.taken);

    tpred_ctr_table #(
        .IDX_W (META_IDX_W),
        .INIT  (SEL_WEAK_GLOBAL)
    ) u_meta (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (lk_idx),
        .rd_ctr (lk_ctr),
        .rs_idx (rs_idx),
        .rs_ctr (rs_ctr),
        .wr_en  (rs.valid && disagree),
        .wr_ctr (ctr_step(rs_ctr, global_right))
    );

    assign lk_pick = pick_from(lk_ctr);
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
    import tpred_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int LHT_IDX_W  = 10,
    parameter int LHIST_W    = 10,
    parameter int GHIST_W    = 12,
    parameter int META_IDX_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic            rs_local_pred,
    input  logic            rs_global_pred
);
    localparam int PC_USED = (LHT_IDX_W > META_IDX_W) ? LHT_IDX_W : META_IDX_W;

    outcome_t           rs;
    pick_e              pick;
    logic [GHIST_W-1:0] ghr_q;

    assign rs = '{valid:       rs_valid,
                  taken:       rs_taken,
                  local_pred:  rs_local_pred,
                  global_pred: rs_global_pred};

    generate
        if (PC_W > PC_USED) begin : g_hi_pc
            logic unused_hi_pc;
            assign unused_hi_pc = ^{lk_pc[PC_W-1:PC_USED], rs_pc[PC_W-1:PC_USED]};
        end
    endgenerate

    tpred_local #(
        .LHT_IDX_W (LHT_IDX_W),
        .LHIST_W   (LHIST_W)
    ) u_loc (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (lk_pc[LHT_IDX_W-1:0]),
        .lk_taken (pred_local),
        .rs_idx   (rs_pc[LHT_IDX_W-1:0]),
        .rs_en    (rs.valid),
        .rs_taken (rs.taken)
    );

    tpred_global #(
        .GHIST_W (GHIST_W)
    ) u_glob (
        .clk      (clk),
        .rst      (rst),
        .lk_taken (pred_global),
        .rs_en    (rs.valid),
        .rs_taken (rs.taken),
        .ghr      (ghr_q)
    );

    tpred_chooser #(
        .META_IDX_W (META_IDX_W)
    ) u_sel (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (lk_pc[META_IDX_W-1:0]),
        .lk_pick (pick),
        .rs_idx  (rs_pc[META_IDX_W-1:0]),
        .rs      (rs)
    );

    always_comb begin
        unique case (pick)
            PICK_GLOBAL: pred_taken = pred_global;
            default:     pred_taken = pred_local;
        endcase
    end
endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
    parameter int GHIST_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               rs_valid,
    input logic               rs_taken,
    input logic               pred_taken,
    input logic               pred_local,
    input logic               pred_global,
    input logic [GHIST_W-1:0] ghr
);
    // R7: with no resolve the shared history is frozen
    p_idle_hist_r7: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |=> $stable(ghr));

    // R3: newest outcome lands in bit 0
    p_hist_newest_r3: assert property (@(posedge clk) disable iff (rst)
        rs_valid |=> (ghr[0] == $past(rs_taken)));

    generate
        if (GHIST_W > 1) begin : g_age
            // R3: older outcomes move up one place
            p_hist_age_r3: assert property (@(posedge clk) disable iff (rst)
                rs_valid |=> (ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0])));
        end
    endgenerate

    // R4: when both components agree the chooser cannot matter
    p_agree_r4: assert property (@(posedge clk) disable iff (rst)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

    // R8: first cycle after reset shows a clean state
    p_reset_clean_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ghr == '0 && !pred_local && !pred_global && !pred_taken));
endmodule

bind tourn_pred tourn_pred_chk #(.GHIST_W(GHIST_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rs_valid    (rs_valid),
    .rs_taken    (rs_taken),
    .pred_taken  (pred_taken),
    .pred_local  (pred_local),
    .pred_global (pred_global),
    .ghr         (ghr_q)
);

// File: tb/tourn_pred_tb.sv
module tourn_pred_tb;
    localparam int PC_W = 8;
    localparam int NVEC = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] lk_pc = '0;
    logic            pred_taken, pred_local, pred_global;
    logic            rs_valid = 1'b0;
    logic [PC_W-1:0] rs_pc = '0;
    logic            rs_taken = 1'b0;
    logic            rs_local_pred = 1'b0;
    logic            rs_global_pred = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tourn_pred #(
        .PC_W       (PC_W),
        .LHT_IDX_W  (2),
        .LHIST_W    (2),
        .GHIST_W    (2),
        .META_IDX_W (2)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .lk_pc          (lk_pc),
        .pred_taken     (pred_taken),
        .pred_local     (pred_local),
        .pred_global    (pred_global),
        .rs_valid       (rs_valid),
        .rs_pc          (rs_pc),
        .rs_taken       (rs_taken),
        .rs_local_pred  (rs_local_pred),
        .rs_global_pred (rs_global_pred)
    );

    // {pc, outcome, expected local, expected global, expected final}
    // worked out from the requirements, starting from reset
    localparam logic [11:0] VEC [NVEC] = '{
        {8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'd1, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd2, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'd3, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd3, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'd3, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input logic el, input logic eg,
                        input logic ef, input string tag);
        @(negedge clk);
        rs_valid = 1'b0;
        lk_pc    = pc;
        #1;
        chk(pred_local,  el, {tag, " R2 local"});
        chk(pred_global, eg, {tag, " R3 global"});
        chk(pred_taken,  ef, {tag, " R4 final"});
    endtask

    task automatic step(input logic [PC_W-1:0] pc, input logic tk, input logic el,
                        input logic eg, input logic ef, input string tag);
        look(pc, el, eg, ef, tag);
        rs_pc          = pc;
        rs_taken       = tk;
        rs_local_pred  = pred_local;
        rs_global_pred = pred_global;
        rs_valid       = 1'b1;
        @(posedge clk);
        #1;
        rs_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst   = 1'b0;
        lk_pc = 8'd3;
        #1;
        chk(pred_local,  1'b0, "R8 reset local");
        chk(pred_global, 1'b0, "R8 reset global");
        chk(pred_taken,  1'b0, "R8 reset final");

        // R1 R2 R3 R4 R5 R6 R9: trained sequence, checked before each update
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][11:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
                 $sformatf("vec%0d R1 R5 R6", i));
        end

        // R7: resolve data toggles with rs_valid low
        @(negedge clk);
        rs_pc          = 8'd3;
        rs_taken       = 1'b0;
        rs_local_pred  = 1'b1;
        rs_global_pred = 1'b0;
        repeat (4) @(posedge clk);
        look(8'd3, 1'b1, 1'b1, 1'b1, "R7 idle");

        // R1: counter at 3 keeps predicting taken after one miss
        step(8'd3, 1'b0, 1'b1, 1'b1, 1'b1, "R1 pre-miss");
        look(8'd0, 1'b1, 1'b0, 1'b0, "R1 hysteresis");

        // R9: upper address bits ignored
        look(8'd4, 1'b1, 1'b0, 1'b0, "R9 alias");

        // R8: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        look(8'd3, 1'b0, 1'b0, 1'b0, "R8 rerun");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule